// File: doc/BRIEF.md
# Range-Matched LRU Translation Cache

This block caches address translations in a small fully associative array. Each slot holds a virtual base, a region size given as a power-of-two exponent, a physical base and a flag that marks the translation as global. A lookup compares one virtual address against every valid slot in the same cycle. It reports whether the address falls inside any stored region and, on a hit, gives the physical address. The slot's physical base supplies the high bits and the virtual address supplies the offset bits inside the region.

Each slot has its own region size, so translations of different granularities share one array. Replacement follows exact least-recently-used order. That order is kept as a permutation of age ranks across all slots. An insert fills a free slot when one exists and evicts the oldest slot only when every slot is in use. Two flush commands clear the array: one clears everything, the other keeps global translations. A lookup can ask to refresh the recency of the slot it hits, or it can leave the recency order alone.

Top module: `xlat_lru_buf`

## Requirements
- R1: A slot matches address A when the slot is valid, its virtual base is at most A, and A is strictly less than base + 2^exp, with the sum computed without overflow. Both range ends are exact.
- R2: On a hit, `lk_pa` equals the physical base ORed with (A AND (2^exp − 1)). On a miss, `lk_pa` is zero.
- R3: An insert writes into a slot that is not in use whenever such a slot exists. It evicts a valid slot only when all slots are valid, and the slot it evicts is the least recently used one.
- R4: A newly inserted slot becomes the most recently used one. The age ranks of all slots always form a permutation of 0..N−1.
- R5: A lookup with `lk_touch`=1 that hits makes the hit slot the most recently used. With `lk_touch`=0 the recency order does not change.
- R6: `inv_all` marks every slot as unused at the next clock edge.
- R7: `inv_local` frees only the slots whose global flag is 0. Global slots keep their contents and their relative recency.
- R8: `lk_hit` is 1 only while `lk_req` is 1 and some valid slot matches. A lookup that matches nothing reports a miss.
- R9: When several valid slots match, the result comes from the most recently used of them.
- R10: After reset no slot is valid.
- R11: Same-cycle precedence is `inv_all`, then `inv_local`, then insert, then lookup refresh. An insert in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | AW | Lookup virtual address |
| lk_touch | input | 1 | Refresh recency of the hit slot |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_pa | output | AW | Translated physical address |
| ins_en | input | 1 | Insert a translation |
| ins_va | input | AW | Virtual base of the new region |
| ins_pa | input | AW | Physical base of the new region |
| ins_exp | input | LGW | Region size exponent (size = 2^exp) |
| ins_glob | input | 1 | New translation is global |
| inv_all | input | 1 | Free every slot |
| inv_local | input | 1 | Free every non-global slot |

## Verification
Some properties are checked on every cycle. The age ranks must stay a permutation. An insert must land in a free slot while one exists and must come out as rank 0. A refresh-free lookup must leave the ranks untouched. A full flush must empty the array, a selective flush must leave the global slots intact, and a hit must never appear without a request. Other behaviour can only be shown by the bench's scenarios. These are the exact range boundaries for aligned and unaligned bases, the physical address composition, and which slot gets evicted after a sequence of refreshed and unrefreshed hits. The bench also shows that the most recent of two overlapping regions wins, that the eviction order after a selective flush is correct, and that an insert is dropped when it coincides with a flush.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  // State-changing operation applied at a clock edge, highest priority first.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FLUSH_ALL,
    OP_FLUSH_LOCAL,
    OP_INSERT,
    OP_TOUCH
  } xlb_op_e;
endpackage

// File: rtl/xlb_match.sv
module xlb_match #(
  parameter int AW  = 32,
  parameter int LGW = 5
) (
  input  logic           req,
  input  logic           valid,
  input  logic [AW-1:0]  vbase,
  input  logic [LGW-1:0] exp_sz,
  input  logic [AW-1:0]  va,
  output logic           hit
);
  logic [AW:0] top_excl;

  always_comb begin
    top_excl = {1'b0, vbase} + ((AW+1)'(1) << exp_sz);
    hit = req && valid && (va >= vbase) && ({1'b0, va} < top_excl);
  end
endmodule

// File: rtl/xlb_select.sv
module xlb_select #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic [N-1:0]         hit_vec,
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][RW-1:0] rank,
  output logic                 any_hit,
  output logic [RW-1:0]        hit_idx,
  output logic [RW-1:0]        victim_idx
);
  logic [RW-1:0] best;
  logic          have_free;

  // Youngest matching slot wins.
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i] && (!any_hit || rank[i] < best)) begin
        any_hit = 1'b1;
        best    = rank[i];
        hit_idx = RW'(i);
      end
    end
  end

  // Lowest free slot, else the oldest slot.
  always_comb begin
    have_free  = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !have_free) begin
        have_free  = 1'b1;
        victim_idx = RW'(i);
      end
    end
    if (!have_free) begin
      for (int i = 0; i < N; i++) begin
        if (rank[i] == RW'(N-1)) victim_idx = RW'(i);
      end
    end
  end
endmodule

// File: rtl/xlb_recency.sv
module xlb_recency #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch_en,
  input  logic [RW-1:0]        touch_idx,
  output logic [N-1:0][RW-1:0] rank_q
);
  logic [RW-1:0] pivot;

  assign pivot = rank_q[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rank_q[i] <= RW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (RW'(i) == touch_idx)  rank_q[i] <= '0;
        else if (rank_q[i] < pivot) rank_q[i] <= rank_q[i] + RW'(1);
      end
    end
  end
endmodule

// File: rtl/xlat_lru_buf.sv
module xlat_lru_buf #(
  parameter int N_ENTRIES = 8,
  parameter int AW        = 32,
  parameter int LGW       = $clog2(AW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lk_req,
  input  logic [AW-1:0]  lk_va,
  input  logic           lk_touch,
  output logic           lk_hit,
  output logic [AW-1:0]  lk_pa,
  input  logic           ins_en,
  input  logic [AW-1:0]  ins_va,
  input  logic [AW-1:0]  ins_pa,
  input  logic [LGW-1:0] ins_exp,
  input  logic           ins_glob,
  input  logic           inv_all,
  input  logic           inv_local
);
  import xlb_pkg::*;

  localparam int RW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0]           valid_q;
  logic [N_ENTRIES-1:0]           glob_q;
  logic [N_ENTRIES-1:0][AW-1:0]   vbase_q;
  logic [N_ENTRIES-1:0][AW-1:0]   pbase_q;
  logic [N_ENTRIES-1:0][LGW-1:0]  exp_q;
  logic [N_ENTRIES-1:0][RW-1:0]   rank_q;
  logic [N_ENTRIES-1:0]           hit_vec;
  logic                           any_hit;
  logic [RW-1:0]                  hit_idx;
  logic [RW-1:0]                  victim_idx;
  logic [AW-1:0]                  off_mask;
  xlb_op_e                        op;
  logic                           touch_en;
  logic [RW-1:0]                  touch_idx;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    xlb_match #(.AW(AW), .LGW(LGW)) u_match (
      .req(lk_req), .valid(valid_q[g]), .vbase(vbase_q[g]),
      .exp_sz(exp_q[g]), .va(lk_va), .hit(hit_vec[g])
    );
  end

  xlb_select #(.N(N_ENTRIES), .RW(RW)) u_sel (
    .hit_vec(hit_vec), .valid(valid_q), .rank(rank_q),
    .any_hit(any_hit), .hit_idx(hit_idx), .victim_idx(victim_idx)
  );

  always_comb begin
    off_mask = (AW'(1) << exp_q[hit_idx]) - AW'(1);
    lk_hit   = any_hit;
    lk_pa    = any_hit ? (pbase_q[hit_idx] | (lk_va & off_mask)) : '0;
  end

  always_comb begin
    if (inv_all)                  op = OP_FLUSH_ALL;
    else if (inv_local)           op = OP_FLUSH_LOCAL;
    else if (ins_en)              op = OP_INSERT;
    else if (lk_touch && any_hit) op = OP_TOUCH;
    else                          op = OP_IDLE;
    touch_en  = (op == OP_INSERT) || (op == OP_TOUCH);
    touch_idx = (op == OP_INSERT) ? victim_idx : hit_idx;
  end

  xlb_recency #(.N(N_ENTRIES), .RW(RW)) u_age (
    .clk(clk), .rst(rst), .touch_en(touch_en),
    .touch_idx(touch_idx), .rank_q(rank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      case (op)
        OP_FLUSH_ALL:   valid_q <= '0;
        OP_FLUSH_LOCAL: valid_q <= valid_q & glob_q;
        OP_INSERT:      valid_q[victim_idx] <= 1'b1;
        default:        valid_q <= valid_q;
      endcase
    end
  end

  // Payload without reset, written only on insert.
  always_ff @(posedge clk) begin
    if (op == OP_INSERT) begin
      vbase_q[victim_idx] <= ins_va;
      pbase_q[victim_idx] <= ins_pa;
      exp_q[victim_idx]   <= ins_exp;
      glob_q[victim_idx]  <= ins_glob;
    end
  end
endmodule

// File: rtl/xlb_checks.sv
module xlb_checks #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lk_req,
  input logic                 lk_touch,
  input logic                 lk_hit,
  input logic                 ins_en,
  input logic                 inv_all,
  input logic                 inv_local,
  input logic [N-1:0]         valid_q,
  input logic [N-1:0]         glob_q,
  input logic [N-1:0][RW-1:0] rank_q,
  input logic [RW-1:0]        vic_idx
);
  for (genvar r = 0; r < N; r++) begin : g_perm
    logic [N-1:0] holders;
    for (genvar i = 0; i < N; i++) begin : g_h
      assign holders[i] = (rank_q[i] == RW'(r));
    end
    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
      $countones(holders) == 1); // R4
  end

  AST_INSERT_BECOMES_MRU: assert property (@(posedge clk) disable iff (rst)
    ins_en && !inv_all && !inv_local |=>
      valid_q[$past(vic_idx)] && rank_q[$past(vic_idx)] == '0); // R4

  AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (rst)
    ins_en && !(&valid_q) |-> !valid_q[vic_idx]); // R3

  AST_QUIET_LOOKUP_KEEPS_ORDER: assert property (@(posedge clk) disable iff (rst)
    !lk_touch && !ins_en && !inv_all && !inv_local |=> $stable(rank_q)); // R5

  AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> valid_q == '0); // R6

  AST_LOCAL_FLUSH_SPARES_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    inv_local && !inv_all |=>
      (valid_q == $past(valid_q & glob_q)) && $stable(rank_q)); // R7

  AST_HIT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_req); // R8
endmodule

bind xlat_lru_buf xlb_checks #(.N(N_ENTRIES), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_touch(lk_touch), .lk_hit(lk_hit),
  .ins_en(ins_en), .inv_all(inv_all), .inv_local(inv_local),
  .valid_q(valid_q), .glob_q(glob_q), .rank_q(rank_q), .vic_idx(victim_idx)
);

// File: tb/xlat_lru_buf_bench.sv
`timescale 1ns/1ps
module xlat_lru_buf_bench;
  localparam int AW  = 32;
  localparam int LGW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_req = 0, lk_touch = 0, ins_en = 0, ins_glob = 0, inv_all = 0, inv_local = 0;
  logic [AW-1:0] lk_va = '0, ins_va = '0, ins_pa = '0;
  logic [LGW-1:0] ins_exp = '0;
  logic lk_hit;
  logic [AW-1:0] lk_pa;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    bit            hit;
    logic [AW-1:0] pa;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  xlat_lru_buf #(.N_ENTRIES(4), .AW(AW), .LGW(LGW)) u_xlat_lru_buf (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va), .lk_touch(lk_touch),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .ins_en(ins_en), .ins_va(ins_va),
    .ins_pa(ins_pa), .ins_exp(ins_exp), .ins_glob(ins_glob),
    .inv_all(inv_all), .inv_local(inv_local)
  );

  task automatic step_clear();
    @(posedge clk); #1;
    lk_req = 0; lk_touch = 0; ins_en = 0; inv_all = 0; inv_local = 0;
  endtask

  task automatic put(input logic [AW-1:0] va, input logic [AW-1:0] pa,
                     input int e, input bit g);
    step_clear();
    ins_en = 1; ins_va = va; ins_pa = pa; ins_exp = LGW'(e); ins_glob = g;
  endtask

  task automatic look(input logic [AW-1:0] va, input bit touch,
                      input bit eh, input logic [AW-1:0] epa, input string tag);
    exp_t x;
    step_clear();
    lk_req = 1; lk_va = va; lk_touch = touch;
    x.hit = eh; x.pa = eh ? epa : '0; x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: compare at the falling edge, away from the state update.
  always @(negedge clk) begin
    if (lk_req) begin
      exp_t x;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: act hit=%0b pa=%h exp none", lk_hit, lk_pa);
      end else begin
        x = sb.pop_front();
        n_cmp++;
        if (lk_hit !== x.hit || lk_pa !== x.pa) begin
          n_bad++;
          $display("FAIL %s: act hit=%0b pa=%h exp hit=%0b pa=%h",
                   x.tag, lk_hit, lk_pa, x.hit, x.pa);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    look(32'h0000_1000, 0, 0, 0, "R10 empty after reset");

    put(32'h0000_1000, 32'h8000_0000, 12, 0);                    // A
    look(32'h0000_1234, 0, 1, 32'h8000_0234, "R1 R2 inside A");
    look(32'h0000_2000, 0, 0, 0, "R1 upper end exclusive");
    look(32'h0000_0FFF, 0, 0, 0, "R1 below base");
    step_clear();
    lk_va = 32'h0000_1234;                                           // no request
    #5;
    n_cmp++;
    if (lk_hit !== 1'b0) begin
      n_bad++; $display("FAIL R8 hit without request: act %0b exp 0", lk_hit);
    end

    put(32'h0000_5100, 32'h7700_0000, 8, 0);                     // B unaligned
    look(32'h0000_51FF, 0, 1, 32'h7700_00FF, "R1 R2 unaligned last byte");
    look(32'h0000_5200, 0, 0, 0, "R1 unaligned end");
    look(32'h0000_50FF, 0, 0, 0, "R1 unaligned below");
    put(32'h0001_0000, 32'h3000_0000, 16, 1);                    // C global
    put(32'h0004_0000, 32'h4000_0000, 12, 0);                    // D, full: D C B A

    look(32'h0000_1010, 0, 1, 32'h8000_0010, "R5 quiet hit on A");
    put(32'h0009_0000, 32'h9000_0000, 12, 0);                    // E evicts A
    look(32'h0000_1010, 0, 0, 0, "R3 R5 LRU A evicted");
    look(32'h0009_0004, 0, 1, 32'h9000_0004, "R4 E present");
    look(32'h0000_5110, 1, 1, 32'h7700_0010, "R5 refresh B");    // B E D C
    put(32'h000A_0000, 32'hA000_0000, 12, 0);                    // F evicts C
    look(32'h0001_0000, 0, 0, 0, "R3 C was LRU");
    look(32'h0000_5110, 0, 1, 32'h7700_0010, "R5 B survived");
    put(32'h0009_0000, 32'hB000_0000, 16, 1);                    // G evicts D: G F B E
    look(32'h0004_0000, 0, 0, 0, "R3 D evicted");
    look(32'h0009_0004, 0, 1, 32'hB000_0004, "R9 youngest overlap wins");

    step_clear(); inv_local = 1;                                 // only G left
    look(32'h000A_0004, 0, 0, 0, "R7 local F freed");
    look(32'h0000_5110, 0, 0, 0, "R7 local B freed");
    look(32'h0009_8000, 0, 1, 32'hB000_8000, "R7 global kept");
    put(32'h000C_0000, 32'hC000_0000, 12, 0);
    put(32'h000D_0000, 32'hD000_0000, 12, 0);
    put(32'h000E_0000, 32'hE000_0000, 12, 0);
    look(32'h0009_8000, 0, 1, 32'hB000_8000, "R3 free slots used first");
    put(32'h000F_0000, 32'hF000_0000, 12, 0);                    // evicts G
    look(32'h0009_8000, 0, 0, 0, "R7 global kept recency, now LRU");
    look(32'h000C_0010, 0, 1, 32'hC000_0010, "R4 H still present");

    step_clear(); inv_all = 1;
    look(32'h000C_0010, 0, 0, 0, "R6 flush all");
    look(32'h000F_0010, 0, 0, 0, "R6 flush all second");
    put(32'h0020_0000, 32'h5000_0000, 12, 0);
    inv_all = 1;                                                 // same cycle
    look(32'h0020_0004, 0, 0, 0, "R11 insert dropped under flush");
    put(32'h0020_0000, 32'h5000_0000, 12, 0);
    look(32'h0020_0004, 0, 1, 32'h5000_0004, "R11 insert after flush");

    step_clear();
    step_clear();
    if (sb.size() != 0) begin
      n_bad++; $display("FAIL scoreboard leftover: act %0d exp 0", sb.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule